// File: doc/BRIEF.md
# Serial Channel Interrupt and Wait/Ready Controller

This block sits next to one asynchronous serial channel. It holds one 8-bit control byte, takes per-character receive events and transmit and line-status strobes, and turns them into an interrupt request, a 3-bit vector modifier and an active-low WAIT/READY handshake pin. The receive side has four modes. Receive interrupts can be off. They can fire once on the first character after the mode is armed. They can fire on every character with a parity error raised as a special condition. They can fire on every character with a parity error treated as an ordinary character.

Software writes the control byte through `cfg_we`/`cfg_wdata`. Pending causes are kept in a small flag set. The interrupt line is high while any flag is set. The vector modifier names the highest-priority cause when vector modification is on and the block serves channel B. An `int_ack` pulse clears the cause being presented. The WAIT/READY pin is combinational, so the CPU sees it in the same cycle as the condition.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After synchronous reset the control byte is 0, no cause is pending, the first-character mode is disarmed, `irq` is 0, `vec_mod` is 000 and `wait_ready_n` is 1.
- R2: With control bit 0 set, an `ext_change` pulse makes `irq` high after the next clock edge. With bit 0 clear the pulse is ignored.
- R3: With control bit 1 set, a `tx_empty` pulse makes `irq` high after the next clock edge. With bit 1 clear the pulse is ignored.
- R4: When control bits 4:3 = 00, `rx_char` pulses raise no request, whether or not they carry a parity error.
- R5: When bits 4:3 = 01, only the first clean character after a write that selects 01 raises a receive request, and later clean characters do nothing. A character with `rx_perr` raises a special condition every time. Any character uses up the arming.
- R6: When bits 4:3 = 10, every character raises a request. A character with `rx_perr` raises a special condition instead of a plain receive request.
- R7: When bits 4:3 = 11, every character raises a plain receive request, including characters that have `rx_perr`.
- R8: Priority, highest first: special condition, receive, transmit, external/status. An `int_ack` clears only the cause being presented. If a cause is set and acknowledged in the same cycle, the new event wins.
- R9: `vec_mod` is 011 for a special condition, 010 for receive, 000 for transmit and 001 for external/status. These codes appear only when control bit 2 is set and `chan_b` is high. Otherwise `vec_mod` is 000.
- R10: When control bit 7 is 0, `wait_ready_n` is 1.
- R11: Ready mode (bit 7 = 1, bit 5 = 1): `wait_ready_n` is 0 exactly when the selected direction is ready. That is `rx_full` when bit 6 = 1 and `tx_free` when bit 6 = 0.
- R12: Wait mode (bit 7 = 1, bit 5 = 0): `wait_ready_n` is 0 exactly when `cpu_xfer` is high and the selected direction is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value |
| chan_b | input | 1 | High when this instance serves channel B |
| rx_char | input | 1 | One-cycle pulse: a character was received |
| rx_perr | input | 1 | Parity error on the character in `rx_char` |
| tx_empty | input | 1 | One-cycle pulse: the transmit buffer became empty |
| ext_change | input | 1 | One-cycle pulse: the external/status lines changed |
| int_ack | input | 1 | Interrupt acknowledge for the presented cause |
| rx_full | input | 1 | Level: the receive buffer holds a character |
| tx_free | input | 1 | Level: the transmit buffer can take a character |
| cpu_xfer | input | 1 | Level: the CPU is attempting a transfer |
| irq | output | 1 | Active-high interrupt request |
| vec_mod | output | 3 | Vector modifier for the presented cause |
| wait_ready_n | output | 1 | Active-low WAIT/READY handshake |

## Verification
Every event input and every control write is registered once. Its effect on `irq` and `vec_mod` therefore appears one clock edge after the input is presented. `wait_ready_n` depends only on the stored control byte and the current level inputs, so it is valid in the same cycle. The bench drives inputs just after a rising edge and checks `wait_ready_n` before the next edge. It then updates its model at that edge and checks `irq` and `vec_mod` just after it. Because of this, a control write is seen by the handshake check one cycle later, and the checks account for that delay.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int CFG_W  = 8;
    localparam int VEC_W  = 3;
    localparam int NCAUSE = 4;

    typedef enum logic [1:0] {
        RXM_OFF       = 2'b00,
        RXM_FIRST     = 2'b01,
        RXM_ALL_SPEC  = 2'b10,
        RXM_ALL_PLAIN = 2'b11
    } rx_mode_e;

    // Field order follows the bit positions of the control byte.
    typedef struct packed {
        logic     wr_en;     // bit 7
        logic     wr_on_rx;  // bit 6
        logic     wr_ready;  // bit 5
        rx_mode_e rx_mode;   // bits 4:3
        logic     stat_vec;  // bit 2
        logic     tx_ie;     // bit 1
        logic     ext_ie;    // bit 0
    } cfg_t;

    // Field order is the priority order, highest first.
    typedef struct packed {
        logic spec;
        logic rx;
        logic tx;
        logic ext;
    } pend_t;

    typedef enum logic [VEC_W-1:0] {
        VC_TX   = 3'd0,
        VC_EXT  = 3'd1,
        VC_RX   = 3'd2,
        VC_SPEC = 3'd3
    } vcode_e;

    function automatic pend_t pick_top(pend_t p);
        pend_t r;
        r = '0;
        if (p.spec)     r.spec = 1'b1;
        else if (p.rx)  r.rx   = 1'b1;
        else if (p.tx)  r.tx   = 1'b1;
        else if (p.ext) r.ext  = 1'b1;
        return r;
    endfunction

    function automatic vcode_e code_of(pend_t top);
        if (top.spec)    return VC_SPEC;
        else if (top.rx) return VC_RX;
        else if (top.ext) return VC_EXT;
        return VC_TX;
    endfunction

endpackage

// File: rtl/sio_cfg_reg.sv
module sio_cfg_reg
    import sio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= cfg_t'(wdata);
    end

endmodule

// File: rtl/sio_rx_event.sv
module sio_rx_event
    import sio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_mode_e mode,
    input  logic     we,
    input  rx_mode_e wmode,
    input  logic     rx_char,
    input  logic     rx_perr,
    output logic     rx_set,
    output logic     spec_set
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (we)
            armed <= (wmode == RXM_FIRST);
        else if (rx_char && mode == RXM_FIRST)
            armed <= 1'b0;
    end

    always_comb begin
        rx_set   = 1'b0;
        spec_set = 1'b0;
        case (mode)
            RXM_FIRST: begin
                if (rx_char) begin
                    if (rx_perr)    spec_set = 1'b1;
                    else if (armed) rx_set   = 1'b1;
                end
            end
            RXM_ALL_SPEC: begin
                if (rx_char) begin
                    if (rx_perr) spec_set = 1'b1;
                    else         rx_set   = 1'b1;
                end
            end
            RXM_ALL_PLAIN: rx_set = rx_char;
            default: ;
        endcase
    end

    AST_RX_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode == RXM_OFF) |-> (!rx_set && !spec_set)); // R4
    AST_FIRST_ONLY_ONCE: assert property (@(posedge clk) disable iff (rst)
        (mode == RXM_FIRST && rx_char && !rx_perr && !we) |=> !(rx_set && mode == RXM_FIRST && !$past(we))); // R5
    AST_PLAIN_NO_SPEC: assert property (@(posedge clk) disable iff (rst)
        (mode == RXM_ALL_PLAIN && rx_char) |-> (rx_set && !spec_set)); // R7

endmodule

// File: rtl/sio_irq_pend.sv
module sio_irq_pend
    import sio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pend_t            set,
    input  logic             int_ack,
    input  logic             vec_on,
    output logic             irq,
    output logic [VEC_W-1:0] vec_mod
);

    pend_t pend, top, clr;

    assign top = pick_top(pend);
    assign clr = int_ack ? top : pend_t'('0);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | set;
    end

    assign irq     = |pend;
    assign vec_mod = (vec_on && irq) ? code_of(top) : VC_TX;

    AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> irq); // R2
    AST_ACK_CLEARS_TOP: assert property (@(posedge clk) disable iff (rst)
        (int_ack && irq && ((top & set) == '0)) |=> ((pend & $past(top)) == '0)); // R8
    AST_IDLE_NO_VEC: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (vec_mod == '0)); // R9

endmodule

// File: rtl/sio_wait_ready.sv
module sio_wait_ready (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_on_rx,
    input  logic wr_ready,
    input  logic rx_full,
    input  logic tx_free,
    input  logic cpu_xfer,
    output logic wait_ready_n
);

    logic dir_ok;

    assign dir_ok = wr_on_rx ? rx_full : tx_free;

    always_comb begin
        if (!wr_en)        wait_ready_n = 1'b1;
        else if (wr_ready) wait_ready_n = !dir_ok;
        else               wait_ready_n = !(cpu_xfer && !dir_ok);
    end

    AST_WR_OFF_HIGH: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> wait_ready_n); // R10
    AST_WAIT_NEEDS_XFER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ready && !cpu_xfer) |-> wait_ready_n); // R12

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
    import sio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             chan_b,
    input  logic             rx_char,
    input  logic             rx_perr,
    input  logic             tx_empty,
    input  logic             ext_change,
    input  logic             int_ack,
    input  logic             rx_full,
    input  logic             tx_free,
    input  logic             cpu_xfer,
    output logic             irq,
    output logic [VEC_W-1:0] vec_mod,
    output logic             wait_ready_n
);

    cfg_t  cfg;
    pend_t set;
    logic  rx_set, spec_set;

    sio_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    sio_rx_event u_rx (
        .clk      (clk),
        .rst      (rst),
        .mode     (cfg.rx_mode),
        .we       (cfg_we),
        .wmode    (rx_mode_e'(cfg_wdata[4:3])),
        .rx_char  (rx_char),
        .rx_perr  (rx_perr),
        .rx_set   (rx_set),
        .spec_set (spec_set)
    );

    always_comb begin
        set.spec = spec_set;
        set.rx   = rx_set;
        set.tx   = tx_empty && cfg.tx_ie;
        set.ext  = ext_change && cfg.ext_ie;
    end

    sio_irq_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .set     (set),
        .int_ack (int_ack),
        .vec_on  (cfg.stat_vec && chan_b),
        .irq     (irq),
        .vec_mod (vec_mod)
    );

    sio_wait_ready u_wr (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (cfg.wr_en),
        .wr_on_rx     (cfg.wr_on_rx),
        .wr_ready     (cfg.wr_ready),
        .rx_full      (rx_full),
        .tx_free      (tx_free),
        .cpu_xfer     (cpu_xfer),
        .wait_ready_n (wait_ready_n)
    );

    AST_CHAN_A_NO_VEC: assert property (@(posedge clk) disable iff (rst)
        !chan_b |-> (vec_mod == 3'b000)); // R9

endmodule

// File: tb/sio_irq_ctrl_bench.sv
module sio_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       chan_b = 1'b1;
    logic       rx_char = 1'b0, rx_perr = 1'b0, tx_empty = 1'b0, ext_change = 1'b0;
    logic       int_ack = 1'b0, rx_full = 1'b0, tx_free = 1'b0, cpu_xfer = 1'b0;
    logic       irq;
    logic [2:0] vec_mod;
    logic       wait_ready_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_cfg;
    logic       m_arm;
    logic [3:0] m_p; // {spec, rx, tx, ext}

    always #4 clk = ~clk;

    sio_irq_ctrl u_sio_irq_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .chan_b(chan_b),
        .rx_char(rx_char), .rx_perr(rx_perr), .tx_empty(tx_empty), .ext_change(ext_change),
        .int_ack(int_ack), .rx_full(rx_full), .tx_free(tx_free), .cpu_xfer(cpu_xfer),
        .irq(irq), .vec_mod(vec_mod), .wait_ready_n(wait_ready_n)
    );

    function automatic logic [3:0] top_of(logic [3:0] p);
        if (p[3]) return 4'b1000;
        if (p[2]) return 4'b0100;
        if (p[1]) return 4'b0010;
        if (p[0]) return 4'b0001;
        return 4'b0000;
    endfunction

    function automatic logic [2:0] exp_vec(logic [7:0] c, logic b, logic [3:0] p);
        if (!(c[2] && b) || p == 4'b0) return 3'd0;
        if (p[3]) return 3'd3;
        if (p[2]) return 3'd2;
        if (p[1]) return 3'd0;
        return 3'd1;
    endfunction

    function automatic logic exp_wr(logic [7:0] c, logic rf, logic tf, logic cx);
        logic ok;
        ok = c[6] ? rf : tf;
        if (!c[7]) return 1'b1;
        if (c[5]) return !ok;
        return !(cx && !ok);
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [3:0] clr, st;
        clr = int_ack ? top_of(m_p) : 4'b0;
        st = 4'b0;
        st[0] = ext_change && m_cfg[0];
        st[1] = tx_empty && m_cfg[1];
        if (rx_char) begin
            case (m_cfg[4:3])
                2'b01: begin if (rx_perr) st[3] = 1'b1; else if (m_arm) st[2] = 1'b1; end
                2'b10: begin if (rx_perr) st[3] = 1'b1; else st[2] = 1'b1; end
                2'b11: st[2] = 1'b1;
                default: ;
            endcase
        end
        m_p = (m_p & ~clr) | st;
        if (cfg_we) m_arm = (cfg_wdata[4:3] == 2'b01);
        else if (rx_char && m_cfg[4:3] == 2'b01) m_arm = 1'b0;
        if (cfg_we) m_cfg = cfg_wdata;
    endtask

    // Inputs are set shortly after a rising edge; one call spans one cycle.
    task automatic tick(string req);
        #1;
        check(req, "wait_ready_n", {7'b0, wait_ready_n}, {7'b0, exp_wr(m_cfg, rx_full, tx_free, cpu_xfer)});
        @(posedge clk);
        model_step();
        #1;
        check(req, "irq", {7'b0, irq}, {7'b0, (m_p != 4'b0)});
        check(req, "vec_mod", {5'b0, vec_mod}, {5'b0, exp_vec(m_cfg, chan_b, m_p)});
        cfg_we = 1'b0; rx_char = 1'b0; rx_perr = 1'b0; tx_empty = 1'b0;
        ext_change = 1'b0; int_ack = 1'b0;
    endtask

    task automatic wr_cfg(logic [7:0] v, string req);
        cfg_we = 1'b1; cfg_wdata = v; tick(req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        m_cfg = '0; m_arm = 1'b0; m_p = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        tick("R1");
        // R4: mode 00 ignores characters
        wr_cfg(8'b0000_0100, "R4");
        rx_char = 1'b1; tick("R4");
        rx_char = 1'b1; rx_perr = 1'b1; tick("R4");
        // R5: first-character mode
        wr_cfg(8'b0000_1100, "R5");
        rx_char = 1'b1; tick("R5");
        int_ack = 1'b1; tick("R5");
        rx_char = 1'b1; tick("R5");
        rx_char = 1'b1; tick("R5");
        rx_char = 1'b1; rx_perr = 1'b1; tick("R5");
        int_ack = 1'b1; tick("R5");
        wr_cfg(8'b0000_1100, "R5");
        rx_char = 1'b1; tick("R5");
        int_ack = 1'b1; tick("R5");
        // R6: every char, parity special
        wr_cfg(8'b0001_0100, "R6");
        rx_char = 1'b1; rx_perr = 1'b1; tick("R6");
        rx_char = 1'b1; tick("R6");
        int_ack = 1'b1; tick("R6");
        int_ack = 1'b1; tick("R6");
        // R7: every char, parity ordinary
        wr_cfg(8'b0001_1100, "R7");
        rx_char = 1'b1; rx_perr = 1'b1; tick("R7");
        int_ack = 1'b1; tick("R7");
        // R2 / R3: enables
        wr_cfg(8'b0000_0100, "R2");
        ext_change = 1'b1; tx_empty = 1'b1; tick("R3");
        wr_cfg(8'b0000_0111, "R2");
        ext_change = 1'b1; tick("R2");
        tx_empty = 1'b1; tick("R3");
        // R8: priority and acknowledge
        wr_cfg(8'b0001_0111, "R8");
        rx_char = 1'b1; rx_perr = 1'b1; tick("R8");
        int_ack = 1'b1; tick("R8");
        int_ack = 1'b1; tick("R8");
        int_ack = 1'b1; tick("R8");
        ext_change = 1'b1; int_ack = 1'b1; tick("R8");
        int_ack = 1'b1; tick("R8");
        // R9: channel A gives no code
        tx_empty = 1'b1; chan_b = 1'b0; tick("R9");
        chan_b = 1'b1; tick("R9");
        int_ack = 1'b1; tick("R9");
        // R10..R12: handshake pin
        wr_cfg(8'b0110_0000, "R10");
        rx_full = 1'b1; tx_free = 1'b1; cpu_xfer = 1'b1; tick("R10");
        wr_cfg(8'b1110_0000, "R11");
        rx_full = 1'b1; tick("R11");
        rx_full = 1'b0; tick("R11");
        wr_cfg(8'b1010_0000, "R11");
        tx_free = 1'b1; tick("R11");
        tx_free = 1'b0; tick("R11");
        wr_cfg(8'b1000_0000, "R12");
        cpu_xfer = 1'b1; tx_free = 1'b0; tick("R12");
        cpu_xfer = 1'b1; tx_free = 1'b1; tick("R12");
        cpu_xfer = 1'b0; tx_free = 1'b0; tick("R12");
        wr_cfg(8'b1100_0000, "R12");
        cpu_xfer = 1'b1; rx_full = 1'b0; tick("R12");
        // Random mix against the model
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            cfg_we     = ($urandom % 16) == 0;
            cfg_wdata  = 8'($urandom);
            chan_b     = ($urandom % 4) != 0;
            rx_char    = ($urandom % 3) == 0;
            rx_perr    = ($urandom % 4) == 0;
            tx_empty   = ($urandom % 5) == 0;
            ext_change = ($urandom % 6) == 0;
            int_ack    = ($urandom % 3) == 0;
            rx_full    = 1'($urandom);
            tx_free    = 1'($urandom);
            cpu_xfer   = 1'($urandom);
            tick("R8");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule